// File: doc/BRIEF.md
# Prioritised Interrupt Vector Unit

This unit collects interrupt requests from eight external pins and eight internal level sources, keeps one pending bit and one enable bit per source, and drives one request line to the processor core. Alongside that line it presents a 32-bit vector word. The word names the enabled pending source with the highest priority as a 6-bit code. Software that has taken the interrupt reads this word and dispatches on it.

The code sits in the top six bits of the word. On a big-endian bus, a byte read of the word's first byte therefore returns the code times 4, which is an offset into a table of one-word branch instructions. A halfword read returns the code times 1024, which selects one of 64 handlers spaced 1 KB apart. Each external pin can be set for level or rising-edge sensing, and pass through a two-stage synchroniser first. A latched edge is acknowledged by writing a one to its pending bit through a small configuration write port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all pending bits, all enable bits and all edge-select bits are 0, `irq_o` is 0 and `vector_o` reads 32'hFC00_0000, which holds the idle code.
- R2: `vector_o` carries the 6-bit code in bits [31:26] and zeros below. Bits [31:24] therefore equal code*4 and bits [31:16] equal code*1024.
- R3: Source index 2k is external pin k and index 2k+1 is internal level k. Both the pending and the enable vectors use this layout. The lowest enabled pending index wins, and the code equals twice that index.
- R4: A pin in level mode (edge-select bit 0) has its pending bit follow the pin. The change becomes visible after the third rising clock edge, counting the edge that first samples the pin. A write-one-to-clear on that bit has no effect.
- R5: A pin in edge mode (edge-select bit 1) sets its pending bit on a 0-to-1 transition, visible after the third rising clock edge. The bit stays set after the pin falls and is cleared only by writing 1 to it with `cfg_sel_i`=2. Writing 0 there has no effect.
- R6: If a new edge and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R7: An internal level's pending bit follows `int_lvl_i` one clock later and cannot be cleared by a write.
- R8: `cfg_sel_i`=0 loads the edge-select bits from `cfg_wdata_i[7:0]`, and `cfg_sel_i`=1 loads the enable bits. A disabled source still shows in `pend_o` but does not influence `irq_o` or `vector_o`. `irq_o` is 1 exactly when some pending source is enabled.
- R9: When no enabled source is pending, the code is 63 (6'h3F).
- R10: A write with `cfg_sel_i`=3 changes no state.
- R11: An edge-mode pin held high after its acknowledge does not set the pending bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 8 | External interrupt pins, active high, asynchronous |
| int_lvl_i | input | 8 | Internal level requests, synchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 edge select, 1 enable, 2 pending clear, 3 reserved |
| cfg_wdata_i | input | 16 | Write data in source-index layout |
| irq_o | output | 1 | Request to the core |
| vector_o | output | 32 | Vector word, code in bits [31:26] |
| pend_o | output | 16 | Pending bits |
| mask_o | output | 16 | Enable bits |

## Verification
The priority encoder is exercised with single sources at both ends of the order, which shows that pins and levels interleave. It is also driven with mixed pin and level sets, where the winner proves that a lower index beats a higher one regardless of kind. All-sources-active cases with sparse enable patterns separate the enable gating from the pending state. Directed sequences cover the edge-mode life cycle, the clear that collides with a new edge, pins held high after acknowledge, the synchroniser latency in level mode, and writes that must have no effect.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int CODE_W = 6;
    localparam int VEC_W  = 32;
    localparam logic [CODE_W-1:0] IDLE_CODE = 6'h3F;

    typedef enum logic [1:0] {
        SEL_EDGE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2,
        SEL_RSVD = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] stg;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stg[k] = s_q.stg[k-1];
        end
        s_d.prev = s_q.stg[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_o  = s_q.stg[STAGES-1];
    assign rise_o = lvl_o & ~s_q.prev;

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R11
        rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[k] |=> !rise_o[k]);
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_PIN = 8,
    localparam int N_SRC = 2 * N_PIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] edge_sel_i,
    input  logic [N_PIN-1:0] pin_lvl_i,
    input  logic [N_PIN-1:0] pin_rise_i,
    input  logic [N_PIN-1:0] int_lvl_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_bits_i,
    output logic [N_SRC-1:0] pend_o
);
    logic [N_SRC-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        for (int k = 0; k < N_PIN; k++) begin
            if (edge_sel_i[k]) begin
                if (pin_rise_i[k])
                    pend_d[2*k] = 1'b1;
                else if (clr_we_i && clr_bits_i[2*k])
                    pend_d[2*k] = 1'b0;
            end else begin
                pend_d[2*k] = pin_lvl_i[k];
            end
            pend_d[2*k+1] = int_lvl_i[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    for (genvar k = 0; k < N_PIN; k++) begin : g_chk
        // R5
        edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_sel_i[k] && pin_rise_i[k]) |=> pend_q[2*k]);
        // R4
        lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !edge_sel_i[k] |=> (pend_q[2*k] == $past(pin_lvl_i[k])));
        // R7
        int_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (pend_q[2*k+1] == $past(int_lvl_i[k])));
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 16,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int N_PIN       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int N_SRC = 2 * N_PIN,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] ext_irq_i,
    input  logic [N_PIN-1:0] int_lvl_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic [N_SRC-1:0] cfg_wdata_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] mask_o
);
    typedef struct packed {
        logic [N_PIN-1:0] edge_sel;
        logic [N_SRC-1:0] mask;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    cfg_sel_e         sel;
    logic [N_PIN-1:0] pin_lvl, pin_rise;
    logic [N_SRC-1:0] pend, enabled;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [CODE_W-1:0] code;

    assign sel = cfg_sel_e'(cfg_sel_i);

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            case (sel)
                SEL_EDGE: cfg_d.edge_sel = cfg_wdata_i[N_PIN-1:0];
                SEL_MASK: cfg_d.mask     = cfg_wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    irq_pin_sync #(.N(N_PIN), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_irq_i),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise)
    );

    irq_pend_bank #(.N_PIN(N_PIN)) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_sel_i (cfg_q.edge_sel),
        .pin_lvl_i  (pin_lvl),
        .pin_rise_i (pin_rise),
        .int_lvl_i  (int_lvl_i),
        .clr_we_i   (cfg_we_i && (sel == SEL_PEND)),
        .clr_bits_i (cfg_wdata_i),
        .pend_o     (pend)
    );

    assign enabled = pend & cfg_q.mask;

    irq_prio_enc #(.N_SRC(N_SRC)) i_prio (
        .req_i   (enabled),
        .valid_o (win_valid),
        .idx_o   (win_idx)
    );

    assign code     = win_valid ? CODE_W'({win_idx, 1'b0}) : IDLE_CODE;
    assign vector_o = {code, {(VEC_W - CODE_W){1'b0}}};
    assign irq_o    = |enabled;
    assign pend_o   = pend;
    assign mask_o   = cfg_q.mask;

    // R8
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vector_o[VEC_W-1 -: CODE_W] != IDLE_CODE));
    // R9
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (vector_o[VEC_W-1 -: CODE_W] == IDLE_CODE));
    // R3
    winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (enabled[win_idx] &&
                   ((enabled & ((N_SRC'(1) << win_idx) - N_SRC'(1))) == '0)));
    // R10
    rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && sel == SEL_RSVD) |=> $stable(mask_o));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    localparam int NP = 8;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] ext_irq = '0;
    logic [NP-1:0] int_lvl = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [NS-1:0] cfg_wdata = '0;
    logic          irq;
    logic [31:0]   vector;
    logic [NS-1:0] pend, mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk (clk), .rst_n (rst_n), .ext_irq_i (ext_irq), .int_lvl_i (int_lvl),
        .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel), .cfg_wdata_i (cfg_wdata),
        .irq_o (irq), .vector_o (vector), .pend_o (pend), .mask_o (mask)
    );

    // {ext pins, internal levels, enable mask, expected code}
    localparam logic [39:0] VTBL [12] = '{
        {8'h00, 8'h00, 16'hFFFF, 8'd63},
        {8'h01, 8'h00, 16'hFFFF, 8'd0},
        {8'h00, 8'h01, 16'hFFFF, 8'd2},
        {8'h80, 8'h00, 16'hFFFF, 8'd28},
        {8'h00, 8'h80, 16'hFFFF, 8'd30},
        {8'h84, 8'h08, 16'hFFFF, 8'd8},
        {8'h10, 8'h04, 16'hFFFF, 8'd10},
        {8'hFF, 8'hFF, 16'hFFFE, 8'd2},
        {8'hFF, 8'hFF, 16'h8000, 8'd30},
        {8'h20, 8'h00, 16'h0000, 8'd63},
        {8'h06, 8'h02, 16'hFFFB, 8'd6},
        {8'h00, 8'h40, 16'h2000, 8'd26}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [NS-1:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    function automatic logic [NS-1:0] weave(input logic [NP-1:0] e, input logic [NP-1:0] l);
        logic [NS-1:0] r;
        for (int k = 0; k < NP; k++) begin
            r[2*k]   = e[k];
            r[2*k+1] = l[k];
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        // R1 reset state
        check("R1 pend", 32'(pend), 32'h0);
        check("R1 mask", 32'(mask), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 vector", vector, 32'hFC00_0000);
        rst_n = 1'b1;
        tick(2);

        // R2 R3 R8 R9 priority table, level mode
        foreach (VTBL[t]) begin
            logic [7:0] e, l, c;
            logic [15:0] m;
            {e, l, m, c} = VTBL[t];
            cfg_write(2'd1, m);
            ext_irq = e; int_lvl = l;
            tick(4);
            check("R3 code", 32'(vector[31:26]), 32'(c[5:0]));
            check("R2 byte view", 32'(vector[31:24]), 32'(c) * 4);
            check("R2 halfword view", 32'(vector[31:16]), 32'(c) * 1024);
            check("R2 low zeros", 32'(vector[25:0]), 32'h0);
            check("R8 irq", 32'(irq), 32'(c != 8'd63));
            check("R8 pend ignores mask", 32'(pend), 32'(weave(e, l)));
        end
        ext_irq = '0; int_lvl = '0;
        cfg_write(2'd1, 16'hFFFF);
        tick(4);

        // R4 level latency and ignored clear
        ext_irq[3] = 1'b1;
        tick(2);
        check("R4 not yet", 32'(pend[6]), 32'h0);
        tick(1);
        check("R4 visible", 32'(pend[6]), 32'h1);
        cfg_write(2'd2, 16'h0040);
        check("R4 clear ignored", 32'(pend[6]), 32'h1);
        ext_irq[3] = 1'b0;
        tick(3);
        check("R4 follows low", 32'(pend[6]), 32'h0);

        // R5 edge life cycle on pin 1 (index 2)
        cfg_write(2'd0, 16'h0002);
        ext_irq[1] = 1'b1;
        tick(3);
        check("R5 edge set", 32'(pend[2]), 32'h1);
        check("R5 vector", vector, {6'd4, 26'h0});
        ext_irq[1] = 1'b0;
        tick(4);
        check("R5 held after fall", 32'(pend[2]), 32'h1);
        cfg_write(2'd2, 16'h0000);
        check("R5 zero write", 32'(pend[2]), 32'h1);
        cfg_write(2'd2, 16'h0004);
        check("R5 cleared", 32'(pend[2]), 32'h0);
        check("R5 irq idle", 32'(irq), 32'h0);

        // R11 held high after acknowledge
        ext_irq[1] = 1'b1;
        tick(4);
        check("R11 edge again", 32'(pend[2]), 32'h1);
        cfg_write(2'd2, 16'h0004);
        tick(4);
        check("R11 no re-set", 32'(pend[2]), 32'h0);
        ext_irq[1] = 1'b0;

        // R6 clear coinciding with new edge on pin 2 (index 4)
        cfg_write(2'd0, 16'h0004);
        tick(3);
        ext_irq[2] = 1'b1;
        tick(2);
        cfg_write(2'd2, 16'h0010);
        check("R6 set wins", 32'(pend[4]), 32'h1);
        cfg_write(2'd2, 16'h0010);
        check("R6 later clear", 32'(pend[4]), 32'h0);
        ext_irq[2] = 1'b0;
        cfg_write(2'd0, 16'h0000);
        tick(3);

        // R7 internal level
        int_lvl[0] = 1'b1;
        tick(1);
        check("R7 follows", 32'(pend[1]), 32'h1);
        cfg_write(2'd2, 16'h0002);
        check("R7 clear ignored", 32'(pend[1]), 32'h1);
        int_lvl[0] = 1'b0;
        tick(1);
        check("R7 drops", 32'(pend[1]), 32'h0);

        // R10 reserved write
        cfg_write(2'd1, 16'hA5A5);
        cfg_write(2'd3, 16'hFFFF);
        check("R10 mask kept", 32'(mask), 32'hA5A5);
        check("R10 pend kept", 32'(pend), 32'h0);
        check("R9 idle vector", vector, 32'hFC00_0000);

        finish_run();
    end
endmodule